// File: doc/BRIEF.md
# PLL reconfiguration sequencer

This block moves a fractional PLL from one divider setting to another without ever presenting an unstable clock downstream. A single-cycle start pulse supplies the requested output frequency in MHz along with the two post dividers, the reference divider, the feedback divider, an integer-mode flag and a 24-bit fraction. The block copies the request into its own registers. It then parks the clock-mode select on the oscillator bypass and powers the PLL down. Next it writes the divider fields into three control words, powers the PLL back up and polls the lock input at a fixed interval. Once lock is seen, it returns the mode select to the PLL output.

If lock never arrives within the allowed number of polls, the sequence ends with a timeout pulse and the clock stays on the bypass source. A request whose target frequency lies outside the permitted output range is rejected immediately and leaves every output unchanged. The control words drive the PLL's configuration pins directly. The frequency-to-divider computation is done elsewhere.

Top module: `pll_reseq`

## Requirements
- R1: After reset, `clk_mode` is 0 (encodings: 0 = oscillator bypass, 1 = PLL output, 2 = low-power 32.768 kHz source, never driven by the sequence). `pll_ctl0` is 0. `pll_ctl1` has only the power-down bit (bit 13) set. `pll_ctl2` holds `CTL2_KEEP` in bits [31:24] and zero below. `busy` is low.
- R2: An accepted request advances one step per clock in this order: mode to bypass, power-down set, dividers written, power-down cleared, lock wait, mode to PLL output. `done` pulses together with the mode change. With lock already high, `done` is seen 6 clocks after the edge that samples `start`.
- R3: `pll_ctl0` carries post-divider 1 in [14:12] and the feedback divider in [11:0]. `pll_ctl1` carries power-down at 13, integer mode at 12, post-divider 2 in [8:6] and the reference divider in [5:0]. All other bits are 0.
- R4: `pll_ctl2[23:0]` takes the requested fraction only when that fraction is nonzero; otherwise it keeps its previous value. `pll_ctl2[31:24]` never changes.
- R5: Lock is sampled once every `POLL_CYC` clocks, the first time one clock after the power-down bit clears, for at most `POLL_MAX` samples. A lock seen on the last sample still completes with `done`.
- R6: If no sample sees lock, `timeout` pulses on the clock after the last sample. `clk_mode` stays 0 and `busy` falls.
- R7: A start whose target is below `FOUT_MIN_MHZ` (24) or above `FOUT_MAX_MHZ` (1600) gives a `reject` pulse one clock later and changes no other output. Both limits are themselves accepted.
- R8: A start that arrives while `busy` is high is ignored: no `reject`, no second `done`. `busy` stays high until `done` or `timeout`.
- R9: The request inputs are captured on the accepted start; later changes to them do not affect the programmed words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse |
| tgt_mhz | input | 11 | Requested output frequency in MHz, used for the range check |
| pdiv1 | input | 3 | Requested post-divider 1 |
| pdiv2 | input | 3 | Requested post-divider 2 |
| refdiv | input | 6 | Requested reference divider |
| fbdiv | input | 12 | Requested feedback divider |
| int_mode | input | 1 | Requested integer-mode flag (delta-sigma off) |
| frac | input | 24 | Requested fraction |
| pll_lock | input | 1 | Lock indication from the PLL |
| clk_mode | output | 2 | Clock-mode select |
| pll_ctl0 | output | 16 | Control word 0 |
| pll_ctl1 | output | 16 | Control word 1 |
| pll_ctl2 | output | 32 | Control word 2 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Pulse: sequence completed on PLL output |
| timeout | output | 1 | Pulse: lock never seen |
| reject | output | 1 | Pulse: request out of range |

## Verification
Two events can land in the same lock-wait cycle: the final lock sample and the expiry of the poll budget. The bench's lock model rises a set number of clocks after power-down clears. That count is chosen so lock first appears exactly at the last permitted sample, and then one clock later. The first case must end in `done` with the PLL-output mode, and the second in `timeout` with bypass kept. Each is also judged on the exact clock at which the result pulse appears.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

    typedef enum logic [1:0] {
        MODE_SLOW   = 2'd0,
        MODE_NORMAL = 2'd1,
        MODE_DEEP   = 2'd2
    } clk_mode_e;

    localparam int FB_W    = 12;
    localparam int REF_W   = 6;
    localparam int PDIV_W  = 3;
    localparam int FRAC_W  = 24;
    localparam int CTL_W   = 16;
    localparam int CTL2_W  = 32;
    localparam int KEEP_W  = CTL2_W - FRAC_W;

    localparam int C0_PDIV1_LSB = 12;
    localparam int C1_PD_BIT    = 13;
    localparam int C1_INT_BIT   = 12;
    localparam int C1_PDIV2_LSB = 6;

    typedef struct packed {
        logic [PDIV_W-1:0] pdiv1;
        logic [PDIV_W-1:0] pdiv2;
        logic [REF_W-1:0]  refdiv;
        logic [FB_W-1:0]   fbdiv;
        logic              int_mode;
        logic [FRAC_W-1:0] frac;
    } pll_cfg_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_BYPASS,
        SQ_PWRDN,
        SQ_LOAD,
        SQ_PWRUP,
        SQ_LOCKWAIT,
        SQ_RESUME
    } seq_state_e;

endpackage

// File: rtl/pll_reseq_range.sv
module pll_reseq_range #(
    parameter int MHZ_W        = 11,
    parameter int FOUT_MIN_MHZ = 24,
    parameter int FOUT_MAX_MHZ = 1600
) (
    input  logic [MHZ_W-1:0] tgt_mhz,
    output logic             in_range
);
    always_comb begin
        in_range = (int'(tgt_mhz) >= FOUT_MIN_MHZ) && (int'(tgt_mhz) <= FOUT_MAX_MHZ);
    end
endmodule

// File: rtl/pll_reseq_lockwait.sv
module pll_reseq_lockwait #(
    parameter int POLL_CYC = 24,
    parameter int POLL_MAX = 2400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_en,
    input  logic lock,
    output logic lock_seen,
    output logic expired
);
    localparam int INTV_W = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam logic [INTV_W-1:0] INTV_LAST = INTV_W'(POLL_CYC - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

    typedef struct packed {
        logic [INTV_W-1:0] intv;
        logic [POLL_W-1:0] polls;
    } lw_t;

    lw_t lw_q, lw_d;
    logic sample_now;

    always_comb begin
        sample_now = wait_en && (lw_q.intv == '0);
        lock_seen  = sample_now && lock;
        expired    = sample_now && !lock && (lw_q.polls == POLL_LAST);
        lw_d       = lw_q;
        if (!wait_en) begin
            lw_d = '0;
        end else begin
            lw_d.intv = (lw_q.intv == INTV_LAST) ? '0 : lw_q.intv + INTV_W'(1);
            if (sample_now && !lock && (lw_q.polls != POLL_LAST)) begin
                lw_d.polls = lw_q.polls + POLL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lw_q <= '0;
        end else begin
            lw_q <= lw_d;
        end
    end

    // R5: the sample count never passes the budget
    a_r5_poll_cap: assert property (@(posedge clk) disable iff (!rst_n)
        lw_q.polls < POLL_W'(POLL_MAX));

    // R5: leaving the wait restarts the interval and sample count
    a_r5_wait_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_en) |=> (lw_q.polls == '0 && lw_q.intv == '0));

endmodule

// File: rtl/pll_reseq_fsm.sv
module pll_reseq_fsm
    import pll_reseq_pkg::*;
#(
    parameter logic [KEEP_W-1:0] CTL2_KEEP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              range_ok,
    input  pll_cfg_t          cfg_in,
    input  logic              lock_seen,
    input  logic              expired,
    output logic              wait_en,
    output logic              busy,
    output logic [1:0]        mode,
    output logic [CTL_W-1:0]  ctl0,
    output logic [CTL_W-1:0]  ctl1,
    output logic [CTL2_W-1:0] ctl2,
    output logic              done,
    output logic              tout,
    output logic              rej
);
    typedef struct packed {
        seq_state_e        state;
        pll_cfg_t          cfg;
        clk_mode_e         mode;
        logic [CTL_W-1:0]  ctl0;
        logic [CTL_W-1:0]  ctl1;
        logic [CTL2_W-1:0] ctl2;
        logic              done;
        logic              tout;
        logic              rej;
    } seq_t;

    seq_t sq_q, sq_d;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        sq_d.tout = 1'b0;
        sq_d.rej  = 1'b0;
        case (sq_q.state)
            SQ_IDLE: begin
                if (start) begin
                    if (range_ok) begin
                        sq_d.cfg   = cfg_in;
                        sq_d.state = SQ_BYPASS;
                    end else begin
                        sq_d.rej = 1'b1;
                    end
                end
            end
            SQ_BYPASS: begin
                sq_d.mode  = MODE_SLOW;
                sq_d.state = SQ_PWRDN;
            end
            SQ_PWRDN: begin
                sq_d.ctl1[C1_PD_BIT] = 1'b1;
                sq_d.state           = SQ_LOAD;
            end
            SQ_LOAD: begin
                sq_d.ctl0                              = '0;
                sq_d.ctl0[FB_W-1:0]                    = sq_q.cfg.fbdiv;
                sq_d.ctl0[C0_PDIV1_LSB +: PDIV_W]      = sq_q.cfg.pdiv1;
                sq_d.ctl1[C1_INT_BIT]                  = sq_q.cfg.int_mode;
                sq_d.ctl1[C1_PDIV2_LSB +: PDIV_W]      = sq_q.cfg.pdiv2;
                sq_d.ctl1[REF_W-1:0]                   = sq_q.cfg.refdiv;
                if (sq_q.cfg.frac != '0) begin
                    sq_d.ctl2[FRAC_W-1:0] = sq_q.cfg.frac;
                end
                sq_d.state = SQ_PWRUP;
            end
            SQ_PWRUP: begin
                sq_d.ctl1[C1_PD_BIT] = 1'b0;
                sq_d.state           = SQ_LOCKWAIT;
            end
            SQ_LOCKWAIT: begin
                if (lock_seen) begin
                    sq_d.state = SQ_RESUME;
                end else if (expired) begin
                    sq_d.tout  = 1'b1;
                    sq_d.state = SQ_IDLE;
                end
            end
            SQ_RESUME: begin
                sq_d.mode  = MODE_NORMAL;
                sq_d.done  = 1'b1;
                sq_d.state = SQ_IDLE;
            end
            default: sq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q                 <= '0;
            sq_q.state           <= SQ_IDLE;
            sq_q.mode            <= MODE_SLOW;
            sq_q.ctl1[C1_PD_BIT] <= 1'b1;
            sq_q.ctl2            <= {CTL2_KEEP, {FRAC_W{1'b0}}};
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        wait_en = (sq_q.state == SQ_LOCKWAIT);
        busy    = (sq_q.state != SQ_IDLE);
        mode    = sq_q.mode;
        ctl0    = sq_q.ctl0;
        ctl1    = sq_q.ctl1;
        ctl2    = sq_q.ctl2;
        done    = sq_q.done;
        tout    = sq_q.tout;
        rej     = sq_q.rej;
    end

    // R2: dividers are written only while bypassed and powered down
    a_r2_load_when_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.state == SQ_LOAD) |-> (sq_q.mode == MODE_SLOW && sq_q.ctl1[C1_PD_BIT]));

    // R2: control word 0 changes only while the PLL is held down
    a_r2_ctl0_while_down: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.ctl0 != $past(sq_q.ctl0)) |-> ($past(sq_q.ctl1[C1_PD_BIT]) && sq_q.ctl1[C1_PD_BIT]));

    // R2: the PLL output is selected only together with done
    a_r2_normal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.mode == MODE_NORMAL && $past(sq_q.mode) != MODE_NORMAL) |-> sq_q.done);

    // R4: the upper bits of control word 2 are preserved
    a_r4_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.ctl2[CTL2_W-1:FRAC_W] == CTL2_KEEP);

    // R6: a timeout leaves the clock on bypass and ends the sequence
    a_r6_tout_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.tout |-> (sq_q.mode == MODE_SLOW && !busy));

    // R7: a rejected request touches nothing
    a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.rej |-> ($stable(sq_q.ctl0) && $stable(sq_q.ctl1) && $stable(sq_q.ctl2) && $stable(sq_q.mode)));

    // R8: result pulses are exclusive
    a_r8_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sq_q.done, sq_q.tout, sq_q.rej}) <= 1);

endmodule

// File: rtl/pll_reseq.sv
module pll_reseq
    import pll_reseq_pkg::*;
#(
    parameter int                MHZ_W        = 11,
    parameter int                FOUT_MIN_MHZ = 24,
    parameter int                FOUT_MAX_MHZ = 1600,
    parameter int                POLL_CYC     = 24,
    parameter int                POLL_MAX     = 2400,
    parameter logic [KEEP_W-1:0] CTL2_KEEP    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MHZ_W-1:0]  tgt_mhz,
    input  logic [PDIV_W-1:0] pdiv1,
    input  logic [PDIV_W-1:0] pdiv2,
    input  logic [REF_W-1:0]  refdiv,
    input  logic [FB_W-1:0]   fbdiv,
    input  logic              int_mode,
    input  logic [FRAC_W-1:0] frac,
    input  logic              pll_lock,
    output logic [1:0]        clk_mode,
    output logic [CTL_W-1:0]  pll_ctl0,
    output logic [CTL_W-1:0]  pll_ctl1,
    output logic [CTL2_W-1:0] pll_ctl2,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic              reject
);
    pll_cfg_t req_cfg;
    logic     range_ok;
    logic     wait_en;
    logic     lock_seen;
    logic     expired;

    always_comb begin
        req_cfg.pdiv1    = pdiv1;
        req_cfg.pdiv2    = pdiv2;
        req_cfg.refdiv   = refdiv;
        req_cfg.fbdiv    = fbdiv;
        req_cfg.int_mode = int_mode;
        req_cfg.frac     = frac;
    end

    pll_reseq_range #(
        .MHZ_W        (MHZ_W),
        .FOUT_MIN_MHZ (FOUT_MIN_MHZ),
        .FOUT_MAX_MHZ (FOUT_MAX_MHZ)
    ) u_range (
        .tgt_mhz  (tgt_mhz),
        .in_range (range_ok)
    );

    pll_reseq_lockwait #(
        .POLL_CYC (POLL_CYC),
        .POLL_MAX (POLL_MAX)
    ) u_lockwait (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_en   (wait_en),
        .lock      (pll_lock),
        .lock_seen (lock_seen),
        .expired   (expired)
    );

    pll_reseq_fsm #(
        .CTL2_KEEP (CTL2_KEEP)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .range_ok  (range_ok),
        .cfg_in    (req_cfg),
        .lock_seen (lock_seen),
        .expired   (expired),
        .wait_en   (wait_en),
        .busy      (busy),
        .mode      (clk_mode),
        .ctl0      (pll_ctl0),
        .ctl1      (pll_ctl1),
        .ctl2      (pll_ctl2),
        .done      (done),
        .tout      (timeout),
        .rej       (reject)
    );

endmodule

// File: tb/sim_pll_reseq.sv
module sim_pll_reseq;
    localparam int CLK_PERIOD = 10;
    localparam int P_CYC      = 4;
    localparam int P_MAX      = 2400;
    localparam logic [7:0] KEEP = 8'h5A;

    typedef struct packed {
        logic [10:0] mhz;
        logic [2:0]  p1;
        logic [2:0]  p2;
        logic [5:0]  rf;
        logic [11:0] fb;
        logic        im;
        logic [23:0] fr;
        logic [31:0] dly;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{11'd1000, 3'd1, 3'd1, 6'd1,  12'd125, 1'b1, 24'h000000, 32'd0},
        '{11'd24,   3'd7, 3'd6, 6'd1,  12'd42,  1'b1, 24'h000000, 32'd10},
        '{11'd1600, 3'd1, 3'd1, 6'd3,  12'd200, 1'b0, 24'h123456, 32'd37},
        '{11'd23,   3'd2, 3'd2, 6'd2,  12'd2,   1'b1, 24'h0000FF, 32'd0},
        '{11'd1601, 3'd3, 3'd3, 6'd3,  12'd3,   1'b1, 24'h000000, 32'd0},
        '{11'd600,  3'd2, 3'd1, 6'd1,  12'd100, 1'b1, 24'h000000, 32'd5},
        '{11'd800,  3'd1, 3'd2, 6'd2,  12'd400, 1'b0, 24'hABCDEF, 32'd9596},
        '{11'd500,  3'd4, 3'd1, 6'd1,  12'd250, 1'b1, 24'h000000, 32'd9597}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] tgt_mhz = '0;
    logic [2:0]  pdiv1 = '0, pdiv2 = '0;
    logic [5:0]  refdiv = '0;
    logic [11:0] fbdiv = '0;
    logic        int_mode = 1'b0;
    logic [23:0] frac = '0;
    logic        pll_lock;
    logic [1:0]  clk_mode;
    logic [15:0] pll_ctl0, pll_ctl1;
    logic [31:0] pll_ctl2;
    logic        busy, done, timeout, reject;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int rej_cnt = 0;

    logic [19:0] lk_cnt;
    logic [31:0] lock_delay = 32'd0;

    logic [15:0] exp_ctl0 = 16'h0000;
    logic [15:0] exp_ctl1 = 16'h2000;
    logic [23:0] exp_lo   = 24'h0;
    logic [1:0]  exp_mode = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_reseq #(
        .POLL_CYC  (P_CYC),
        .POLL_MAX  (P_MAX),
        .CTL2_KEEP (KEEP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_mhz(tgt_mhz),
        .pdiv1(pdiv1), .pdiv2(pdiv2), .refdiv(refdiv), .fbdiv(fbdiv),
        .int_mode(int_mode), .frac(frac), .pll_lock(pll_lock),
        .clk_mode(clk_mode), .pll_ctl0(pll_ctl0), .pll_ctl1(pll_ctl1),
        .pll_ctl2(pll_ctl2), .busy(busy), .done(done), .timeout(timeout),
        .reject(reject)
    );

    // PLL stand-in: lock follows power-up after lock_delay clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_cnt <= '0;
        else if (pll_ctl1[13]) lk_cnt <= '0;
        else if (lk_cnt != 20'hFFFFF) lk_cnt <= lk_cnt + 20'd1;
    end
    assign pll_lock = ({12'd0, lk_cnt} >= lock_delay);

    always_ff @(posedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        if (reject) rej_cnt <= rej_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        tgt_mhz  = v.mhz;
        pdiv1    = v.p1;
        pdiv2    = v.p2;
        refdiv   = v.rf;
        fbdiv    = v.fb;
        int_mode = v.im;
        frac     = v.fr;
    endtask

    // outcome: 0 done, 1 timeout, 2 reject, 3 nothing
    task automatic launch(input vec_t v, output int got, output int n);
        @(negedge clk);
        lock_delay = v.dly;
        drive(v);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        n = 0;
        got = 3;
        if (reject) got = 2;
        while (got == 3 && n < 12000) begin
            @(posedge clk);
            n++;
            #1;
            if (done) got = 0;
            else if (timeout) got = 1;
            else if (reject) got = 2;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int got, n, k, exp_out, exp_lat, d0, r0;
        vec_t va, vb;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        chk(clk_mode == 2'd0, "R1", "mode", clk_mode, 0);
        chk(pll_ctl0 == 16'h0, "R1", "ctl0", pll_ctl0, 0);
        chk(pll_ctl1 == 16'h2000, "R1", "ctl1", pll_ctl1, 16'h2000);
        chk(pll_ctl2 == {KEEP, 24'h0}, "R1", "ctl2", pll_ctl2, {KEEP, 24'h0});
        chk(busy == 1'b0, "R1", "busy", busy, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.mhz < 11'd24 || v.mhz > 11'd1600) begin
                exp_out = 2; exp_lat = 0;
            end else begin
                k = (v.dly + P_CYC - 1) / P_CYC;
                if (k <= P_MAX - 1) begin
                    exp_out = 0; exp_lat = 6 + k * P_CYC;
                end else begin
                    exp_out = 1; exp_lat = 5 + (P_MAX - 1) * P_CYC;
                end
            end
            launch(v, got, n);
            // R2 R5 R6 R7: outcome kind and the clock it appears on
            chk(got == exp_out, "R2/R6/R7", $sformatf("vec%0d outcome", i), got, exp_out);
            chk(n == exp_lat, "R2/R5", $sformatf("vec%0d latency", i), n, exp_lat);
            if (exp_out != 2) begin
                exp_ctl0 = {1'b0, v.p1, v.fb};
                exp_ctl1 = {3'b000, v.im, 3'b000, v.p2, v.rf};
                if (v.fr != 24'h0) exp_lo = v.fr;
                exp_mode = (exp_out == 0) ? 2'd1 : 2'd0;
            end
            chk(pll_ctl0 == exp_ctl0, "R3", $sformatf("vec%0d ctl0", i), pll_ctl0, exp_ctl0);
            chk(pll_ctl1 == exp_ctl1, "R3", $sformatf("vec%0d ctl1", i), pll_ctl1, exp_ctl1);
            chk(pll_ctl2 == {KEEP, exp_lo}, "R4", $sformatf("vec%0d ctl2", i), pll_ctl2, {KEEP, exp_lo});
            chk(clk_mode == exp_mode, "R6", $sformatf("vec%0d mode", i), clk_mode, exp_mode);
            chk(busy == 1'b0, "R6", $sformatf("vec%0d busy", i), busy, 0);
            repeat (3) @(posedge clk);
        end

        // R8 and R9: new inputs and a second start during a sequence
        va = '{11'd700, 3'd2, 3'd2, 6'd1, 12'd300, 1'b1, 24'h0, 32'd8};
        vb = '{11'd5,   3'd5, 3'd3, 6'd9, 12'd999, 1'b0, 24'h777777, 32'd8};
        d0 = done_cnt;
        r0 = rej_cnt;
        @(negedge clk);
        lock_delay = va.dly;
        drive(va);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        drive(vb);
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b1, "R8", "busy mid-sequence", busy, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(posedge clk);
        #1;
        chk(done_cnt - d0 == 1, "R8", "done pulses", done_cnt - d0, 1);
        chk(rej_cnt == r0, "R8", "reject pulses", rej_cnt - r0, 0);
        chk(pll_ctl0 == {1'b0, va.p1, va.fb}, "R9", "ctl0 latched", pll_ctl0, {1'b0, va.p1, va.fb});
        chk(pll_ctl1 == {3'b000, va.im, 3'b000, va.p2, va.rf}, "R9", "ctl1 latched",
            pll_ctl1, {3'b000, va.im, 3'b000, va.p2, va.rf});
        chk(pll_ctl2 == {KEEP, exp_lo}, "R4", "ctl2 after zero fraction", pll_ctl2, {KEEP, exp_lo});
        chk(clk_mode == 2'd1, "R2", "mode after done", clk_mode, 1);

        // R7: a reject while on PLL output leaves the mode alone
        launch('{11'd0, 3'd1, 3'd1, 6'd1, 12'd1, 1'b1, 24'h1, 32'd0}, got, n);
        chk(got == 2 && n == 0, "R7", "reject at zero target", got, 2);
        chk(clk_mode == 2'd1, "R7", "mode kept on reject", clk_mode, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule